// File: doc/BRIEF.md
# Cascaded Ring Clock-Enable Prescaler

This block turns a fast clock into a slow, strictly periodic clock-enable, without a wide binary counter on the divide path. The division ratio N is the integer quotient of the input frequency parameter by the output frequency parameter. While the design elaborates, N is broken into a product of small factors, each between 2 and 31. Each factor becomes a one-hot ring of registers whose length equals that factor.

The rings form a chain. The first ring rotates on every clock. Each later ring rotates only on a cycle in which every ring before it sits on its last position. The last-position taps of all rings are ANDed together into a terminal tick, which is high once every N cycles. A register captures that tick as the enable output. An optional real duty parameter holds the enable high for a number of cycles instead of one. Logic fed by the main clock qualifies its updates with the enable. No derived clock is produced.

Top module: `srp_prescaler`

## Requirements
- R1: While `rst` is sampled high at a clock edge, `ce_out` is 0 after that edge. Every ring reloads a single 1 at its first position, so the pulse timing after release is the same as after the first reset.
- R2: N = IN_HZ / OUT_HZ is split at elaboration into factors from 2 to 31, one ring per factor. Elaboration fails when N < 2 or when N has a prime factor above 31. A prime N of 31 or less gives a single ring and still divides by N.
- R3: A ring other than the first keeps its position on any cycle in which some earlier ring is off its last position. On a cycle in which it does rotate while on its last position, it leaves that position.
- R4: Count rising edges from the first edge at which `rst` is sampled low as edge 1. `ce_out` rises after edge N, and again every N edges after that, with no drift.
- R5: With the default duty of 0.0, `ce_out` stays high for exactly one cycle in every N.
- R6: With a duty D in (0.0, 1.0), `ce_out` stays high for H = round(D·N) consecutive cycles from each rise, then low for the rest of the period.
- R7: H is clamped to the range 1 to N−1. A duty whose rounded product is 0 gives a one-cycle pulse. A duty whose rounded product is N or more leaves exactly one low cycle per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_out | output | 1 | Periodic clock-enable, one period every N clock cycles |

## Verification
The hardest state to reach from the ports is the cycle in which every ring sits on its last position at once. At that cycle the carry runs through the whole AND chain and the late rings rotate. It is visible only as one output edge every N cycles. The bench uses several instances with small, multi-factor ratios (210, 310) and a single-ring prime ratio (31), so this alignment recurs within a few hundred cycles. It compares every cycle against an arithmetic model of the period and width over several periods. It also applies a reset in the middle of a high phase, to show that the rings realign to the first-pulse timing.

// File: rtl/srp_pkg.sv
package srp_pkg;

  localparam int MAX_RING = 31;
  localparam int MAX_PASSES = 32;

  // Largest divisor of n in [2, MAX_RING], or 0 when none exists.
  function automatic int largest_div(input int n);
    int res;
    res = 0;
    for (int d = MAX_RING; d >= 2; d--) begin
      if (res == 0 && (n % d) == 0) res = d;
    end
    return res;
  endfunction

  // Number of rings produced by greedy decomposition of n.
  function automatic int stage_count(input int n);
    int rem;
    int cnt;
    int d;
    rem = n;
    cnt = 0;
    for (int i = 0; i < MAX_PASSES; i++) begin
      if (rem > 1) begin
        d = largest_div(rem);
        if (d != 0) begin
          rem = rem / d;
          cnt++;
        end
      end
    end
    return cnt;
  endfunction

  // Part of n that could not be absorbed into rings (1 when fully split).
  function automatic int leftover(input int n);
    int rem;
    int d;
    rem = n;
    for (int i = 0; i < MAX_PASSES; i++) begin
      if (rem > 1) begin
        d = largest_div(rem);
        if (d != 0) rem = rem / d;
      end
    end
    return rem;
  endfunction

  // Length of ring number idx in the greedy decomposition of n.
  function automatic int stage_len(input int n, input int idx);
    int rem;
    int cnt;
    int d;
    int res;
    rem = n;
    cnt = 0;
    res = 2;
    for (int i = 0; i < MAX_PASSES; i++) begin
      if (rem > 1) begin
        d = largest_div(rem);
        if (d != 0) begin
          if (cnt == idx) res = d;
          rem = rem / d;
          cnt++;
        end
      end
    end
    return res;
  endfunction

  // High-phase length in cycles, rounded and clamped to [1, n-1].
  function automatic int high_cycles(input int n, input real duty);
    int h;
    if (duty <= 0.0) return 1;
    h = $rtoi(duty * real'(n) + 0.5);
    if (h < 1) h = 1;
    if (h > n - 1) h = n - 1;
    return h;
  endfunction

endpackage

// File: rtl/srp_ring.sv
module srp_ring #(
  parameter int LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic term
);

  logic [LEN-1:0] ring_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_q <= LEN'(1);
    end else if (adv) begin
      ring_q <= {ring_q[LEN-2:0], ring_q[LEN-1]};
    end
  end

  assign term = ring_q[LEN-1];

endmodule

// File: rtl/srp_ring_chain.sv
module srp_ring_chain
  import srp_pkg::*;
#(
  parameter int N  = 6,
  parameter int NS = 2
) (
  input  logic          clk,
  input  logic          rst,
  output logic [NS-1:0] stage_adv,
  output logic [NS-1:0] stage_term,
  output logic          tick
);

  logic [NS:0] carry;

  assign carry[0] = 1'b1;

  for (genvar k = 0; k < NS; k++) begin : g_stage
    localparam int LEN = stage_len(N, k);

    srp_ring #(.LEN(LEN)) u_ring (
      .clk  (clk),
      .rst  (rst),
      .adv  (carry[k]),
      .term (stage_term[k])
    );

    assign stage_adv[k] = carry[k];
    assign carry[k+1]   = carry[k] & stage_term[k];
  end

  assign tick = carry[NS];

endmodule

// File: rtl/srp_pulse_stretch.sv
module srp_pulse_stretch #(
  parameter int N    = 6,
  parameter int HIGH = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic ce
);

  localparam int CW = (N > 2) ? $clog2(N) : 1;

  if (HIGH <= 1) begin : g_single
    always_ff @(posedge clk) begin
      if (rst) ce <= 1'b0;
      else     ce <= tick;
    end
  end else begin : g_hold
    logic [CW-1:0] rem_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        ce    <= 1'b0;
        rem_q <= '0;
      end else if (tick) begin
        ce    <= 1'b1;
        rem_q <= CW'(HIGH - 1);
      end else if (rem_q != '0) begin
        rem_q <= rem_q - 1'b1;
      end else begin
        ce <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/srp_prescaler.sv
module srp_prescaler
  import srp_pkg::*;
#(
  parameter int  IN_HZ  = 2100,
  parameter int  OUT_HZ = 10,
  parameter real DUTY   = 0.0
) (
  input  logic clk,
  input  logic rst,
  output logic ce_out
);

  localparam int N      = IN_HZ / OUT_HZ;
  localparam int NS_RAW = stage_count(N);
  localparam int NS     = (NS_RAW < 1) ? 1 : NS_RAW;
  localparam int HIGH   = high_cycles(N, DUTY);

  if (N < 2 || leftover(N) != 1) begin : g_bad_ratio
    $error("prescaler ratio must be at least 2 with prime factors of 31 or less");
  end

  logic [NS-1:0] stage_adv;
  logic [NS-1:0] stage_term;
  logic          tick;

  srp_ring_chain #(.N(N), .NS(NS)) u_chain (
    .clk        (clk),
    .rst        (rst),
    .stage_adv  (stage_adv),
    .stage_term (stage_term),
    .tick       (tick)
  );

  srp_pulse_stretch #(.N(N), .HIGH(HIGH)) u_stretch (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .ce   (ce_out)
  );

endmodule

// File: rtl/srp_prescaler_chk.sv
module srp_prescaler_chk #(
  parameter int N    = 6,
  parameter int HIGH = 1,
  parameter int NS   = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [NS-1:0] stage_adv,
  input logic [NS-1:0] stage_term,
  input logic          tick,
  input logic          ce
);

  localparam int GW = $clog2(N) + 2;

  logic [GW-1:0] gap_q;
  logic [GW-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q <= '0;
      hi_q  <= '0;
    end else begin
      gap_q <= tick ? '0 : gap_q + 1'b1;
      hi_q  <= ce ? hi_q + 1'b1 : '0;
    end
  end

  // R1: reset forces the enable low
  a_r1_reset_low: assert property (@(posedge clk) rst |=> !ce);

  // R4: terminal tick exactly N-1 cycles after reset or previous tick
  a_r4_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    tick |-> gap_q == GW'(N - 1));

  a_r4_gap_bound: assert property (@(posedge clk) disable iff (rst)
    gap_q < GW'(N));

  // R4: enable rises the cycle after the tick
  a_r4_ce_follows_tick: assert property (@(posedge clk) disable iff (rst)
    tick |=> ce);

  // R5/R6/R7: high phase length
  a_r6_high_len: assert property (@(posedge clk) disable iff (rst)
    $fell(ce) |-> hi_q == GW'(HIGH));

  for (genvar k = 0; k < NS; k++) begin : g_hold
    // R3: ring holds when not advanced
    a_r3_ring_hold: assert property (@(posedge clk) disable iff (rst)
      !stage_adv[k] |=> $stable(stage_term[k]));
    // R3: advancing ring leaves its terminal position
    a_r3_ring_leave: assert property (@(posedge clk) disable iff (rst)
      (stage_adv[k] && stage_term[k]) |=> !stage_term[k]);
  end

endmodule

bind srp_prescaler srp_prescaler_chk #(.N(N), .HIGH(HIGH), .NS(NS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .stage_adv  (stage_adv),
  .stage_term (stage_term),
  .tick       (tick),
  .ce         (ce_out)
);

// File: tb/sim_srp_prescaler.sv
module sim_srp_prescaler;

  localparam int ND = 6;
  localparam int NV [ND] = '{210, 210, 210, 210, 31, 310};
  localparam int HV [ND] = '{1, 63, 209, 1, 1, 155};
  localparam int NT = 14;
  // {cycle after release, dut index, expected ce}
  localparam int TBL [NT][3] = '{
    '{30, 4, 0}, '{31, 4, 1}, '{32, 4, 0}, '{62, 4, 1},
    '{209, 0, 0}, '{210, 0, 1}, '{211, 0, 0}, '{211, 3, 0},
    '{272, 1, 1}, '{273, 1, 0}, '{418, 2, 1}, '{419, 2, 0},
    '{420, 0, 1}, '{420, 2, 1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ND-1:0] ce;
  int vecs = 0;
  int errs = 0;
  int k = 0;

  always #10 clk = ~clk;

  srp_prescaler #(.IN_HZ(2100), .OUT_HZ(10)) u0 (.clk(clk), .rst(rst), .ce_out(ce[0]));
  srp_prescaler #(.IN_HZ(2100), .OUT_HZ(10), .DUTY(0.3)) u1 (.clk(clk), .rst(rst), .ce_out(ce[1]));
  srp_prescaler #(.IN_HZ(2100), .OUT_HZ(10), .DUTY(0.999)) u2 (.clk(clk), .rst(rst), .ce_out(ce[2]));
  srp_prescaler #(.IN_HZ(2100), .OUT_HZ(10), .DUTY(0.001)) u3 (.clk(clk), .rst(rst), .ce_out(ce[3]));
  srp_prescaler #(.IN_HZ(310), .OUT_HZ(10)) u4 (.clk(clk), .rst(rst), .ce_out(ce[4]));
  srp_prescaler #(.IN_HZ(3100), .OUT_HZ(10), .DUTY(0.5)) u5 (.clk(clk), .rst(rst), .ce_out(ce[5]));

  function automatic string tag_of(input int idx);
    case (idx)
      0: return "R4/R5";
      1: return "R6";
      2: return "R7";
      3: return "R7";
      4: return "R2";
      default: return "R6";
    endcase
  endfunction

  function automatic logic model(input int cyc, input int idx);
    if (cyc < NV[idx]) return 1'b0;
    return (cyc % NV[idx]) < HV[idx];
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
  endtask

  task automatic check(input string tag, input int idx, input logic exp);
    vecs++;
    if (ce[idx] !== exp) begin
      errs++;
      $display("FAIL %s dut%0d cycle %0d: got %b expected %b", tag, idx, k, ce[idx], exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    k++;
  endtask

  task automatic sweep(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      step();
      for (int d = 0; d < ND; d++) check(tag_of(d), d, model(k, d));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    for (int d = 0; d < ND; d++) check("R1", d, 1'b0);
    rst = 1'b0;
    k = 0;

    // table walk: boundary cycles of each variant
    for (int t = 0; t < NT; t++) begin
      while (k < TBL[t][0]) step();
      check(tag_of(TBL[t][1]), TBL[t][1], TBL[t][2][0]);
    end

    // full per-cycle comparison over several periods
    sweep(4 * 310 - k);

    // reset in the middle of a high phase of u5 (high spans 1240..1394)
    while (k < 1250) step();
    check("R6", 5, 1'b1);
    rst = 1'b1;
    for (int r = 0; r < 3; r++) begin
      step();
      for (int d = 0; d < ND; d++) check("R1", d, 1'b0);
    end
    rst = 1'b0;
    k = 0;
    // R1: timing after release matches first reset
    sweep(700);

    summary();
    $finish;
  end

endmodule